// File: doc/BRIEF.md
# Quarter-wave sine/cosine lookup

This block turns an unsigned phase word into signed fixed-point sine and cosine values. The phase word spans one full turn. Phase value `p` stands for the angle `(p + 0.5) * 2*pi / 2^PHASE_W`. The half-count offset makes the folded table exactly mirror-symmetric. Only the first quadrant is held, in a table of `2^(PHASE_W-2)` rounded magnitudes. That table is computed at elaboration. The other three quadrants are rebuilt in logic. The top two phase bits select the quadrant. In quadrants 1 and 3 the table address is the one's complement of the low bits. In quadrants 2 and 3 the result is negated. Cosine reads its own copy of the same table at the phase plus a quarter turn.

Parameters set the following:
- the phase width and the output width;
- full-scale scaling (non-symmetric) or unit-inclusive scaling (symmetric);
- which outputs exist;
- a fixed sign inversion for each output;
- an optional input register, an optional output register, and extra output pipeline stages.

A pipeline built this way accepts a new phase on every cycle. A data-valid flag travels beside each phase, so the ready output marks exactly the results that came from flagged phases. A clock enable freezes every stage. A synchronous clear and an asynchronous clear zero every stage.

Top module: `sincos_qlut`

## Requirements
- R1: The sine output is within 1 LSB of round(sin((p+0.5)·2π/2^PHASE_W)·S). Here p is the phase and S is the scale set by R3 or R4. Only the required negation is applied on top.
- R2: The cosine output is within 1 LSB of round(cos((p+0.5)·2π/2^PHASE_W)·S). Only the required negation is applied on top.
- R3: With SYMMETRIC=0 the scale S is 2^(OUT_W-1), which gives OUT_W-1 fractional bits. Results are clamped to ±(2^(OUT_W-1)-1), so an output never wraps to the opposite sign near ±1.
- R4: With SYMMETRIC=1 the scale S is 2^(OUT_W-2), which gives one integer bit. Every output lies within ±2^(OUT_W-2).
- R5: NEG_SIN=1 negates the sine output, and NEG_COS=1 negates the cosine output. Each flag acts only on its own output.
- R6: The latency from phase to result is IN_REG + OUT_REG·(1+PIPE) clock cycles. With zero latency the path is purely combinational.
- R7: While ce is low and no clear is active, every register holds its value, so the outputs and rdy do not change.
- R8: When sclr is high at a rising clock edge, every register becomes zero. This happens whatever the value of ce. With OUT_REG=1, the next outputs are sine 0, cosine 0 and rdy 0.
- R9: aclr high zeroes every register at once, without waiting for a clock edge.
- R10: rdy is the nd input delayed by the latency of R6 and held by ce in the same way as the data. rfd is always 1.
- R11: While rst_n is low, all registers are zero. With OUT_REG=1 this means the outputs and rdy read 0.
- R12: An output disabled by EN_SIN=0 or EN_COS=0 reads constant 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aclr | input | 1 | Active-high asynchronous clear of all stages |
| sclr | input | 1 | Active-high synchronous clear of all stages |
| ce | input | 1 | Clock enable for all stages |
| nd | input | 1 | Marks the phase on this cycle as valid |
| phase | input | PHASE_W | Unsigned phase, one count = 1/2^PHASE_W turn |
| rfd | output | 1 | A phase can be accepted (always 1) |
| rdy | output | 1 | Outputs carry the result of a flagged phase |
| sin_o | output | OUT_W | Two's complement sine |
| cos_o | output | OUT_W | Two's complement cosine |

## Verification
The bench sweeps every phase of three small configurations against a real-valued reference. A fold error, such as a missing complement in odd quadrants or a sign applied to the wrong quadrant pair, makes whole quadrants come out mirrored or inverted by hundreds of LSBs. Without the clamp, the non-symmetric peak wraps to the most negative code, and the sweep catches that next to the quarter turn. A wrong latency or a wrong rdy delay makes every sample line up with the neighbouring phase, so that mistake fails across the sweep. The bench also freezes the pipeline with ce low, clears it with sclr while ce is low, and pulses aclr in the middle of a cycle. It can therefore tell a clear gated by the enable, or one that waits for an edge, from one that acts as R8 and R9 require.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  // Rounded first-quadrant magnitude for table entry idx, sampled half a count off the grid.
  function automatic int unsigned quad_sample(int idx, int phase_w, int out_w, bit sym);
    real ang;
    real scale;
    real v;
    int  m;
    int  lim;
    ang   = (real'(idx) + 0.5) * 2.0 * 3.14159265358979323846 / real'(64'd1 << phase_w);
    scale = sym ? real'(64'd1 << (out_w - 2)) : real'(64'd1 << (out_w - 1));
    v     = $sin(ang) * scale;
    m     = $rtoi(v + 0.5);
    lim   = sym ? (1 << (out_w - 2)) : ((1 << (out_w - 1)) - 1);
    if (m > lim) m = lim;
    if (m < 0) m = 0;
    return int'(m);
  endfunction

endpackage

// File: rtl/sincos_quad_rom.sv
module sincos_quad_rom #(
  parameter int PHASE_W = 8,
  parameter int OUT_W   = 12,
  parameter bit SYM     = 1'b0,
  localparam int ADDR_W = PHASE_W - 2,
  localparam int MAG_W  = OUT_W - 1,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [MAG_W-1:0]  mag
);

  logic [MAG_W-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam int unsigned ENT = sincos_pkg::quad_sample(i, PHASE_W, OUT_W, SYM);
    assign tbl[i] = MAG_W'(ENT);
  end

  assign mag = tbl[addr];

endmodule

// File: rtl/sincos_fold.sv
module sincos_fold #(
  parameter int PHASE_W = 8,
  parameter int OUT_W   = 12,
  parameter bit SYM     = 1'b0,
  parameter bit COS     = 1'b0,
  parameter bit NEG     = 1'b0,
  localparam int ADDR_W = PHASE_W - 2,
  localparam int MAG_W  = OUT_W - 1
) (
  input  logic [PHASE_W-1:0]    phase,
  output logic signed [OUT_W-1:0] val
);

  localparam logic [PHASE_W-1:0] OFFS = COS ? PHASE_W'(1 << ADDR_W) : '0;

  logic [PHASE_W-1:0] shifted;
  logic [1:0]         quad;
  logic [ADDR_W-1:0]  addr;
  logic               neg;
  logic [MAG_W-1:0]   mag;
  logic signed [OUT_W-1:0] mag_s;

  always_comb begin
    shifted = phase + OFFS;
    quad    = shifted[PHASE_W-1 -: 2];
    addr    = quad[0] ? ~shifted[ADDR_W-1:0] : shifted[ADDR_W-1:0];
    neg     = quad[1] ^ NEG;
  end

  sincos_quad_rom #(.PHASE_W(PHASE_W), .OUT_W(OUT_W), .SYM(SYM)) u_rom (
    .addr (addr),
    .mag  (mag)
  );

  always_comb begin
    mag_s = $signed({1'b0, mag});
    val   = neg ? -mag_s : mag_s;
  end

endmodule

// File: rtl/sincos_pipe.sv
module sincos_pipe #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         aclr,
  input  logic         sclr,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (D == 0) begin : g_wire
    logic unused_ctl;
    assign unused_ctl = ^{clk, rst_n, aclr, sclr, ce};
    assign q = d;
  end else begin : g_regs
    logic [W-1:0] stg_q [D];
    logic [W-1:0] stg_d [D];

    always_comb begin
      stg_d[0] = sclr ? '0 : (ce ? d : stg_q[0]);
      for (int k = 1; k < D; k++) begin
        stg_d[k] = sclr ? '0 : (ce ? stg_q[k-1] : stg_q[k]);
      end
    end

    always_ff @(posedge clk or negedge rst_n or posedge aclr) begin
      if (!rst_n || aclr) begin
        for (int k = 0; k < D; k++) stg_q[k] <= '0;
      end else begin
        for (int k = 0; k < D; k++) stg_q[k] <= stg_d[k];
      end
    end

    assign q = stg_q[D-1];
  end

endmodule

// File: rtl/sincos_qlut.sv
module sincos_qlut #(
  parameter int PHASE_W  = 8,
  parameter int OUT_W    = 12,
  parameter bit SYMMETRIC = 1'b0,
  parameter bit EN_SIN   = 1'b1,
  parameter bit EN_COS   = 1'b1,
  parameter bit NEG_SIN  = 1'b0,
  parameter bit NEG_COS  = 1'b0,
  parameter bit IN_REG   = 1'b1,
  parameter bit OUT_REG  = 1'b1,
  parameter int PIPE     = 1,
  localparam int IN_D    = IN_REG ? 1 : 0,
  localparam int OUT_D   = OUT_REG ? (1 + PIPE) : 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               aclr,
  input  logic               sclr,
  input  logic               ce,
  input  logic               nd,
  input  logic [PHASE_W-1:0] phase,
  output logic               rfd,
  output logic               rdy,
  output logic [OUT_W-1:0]   sin_o,
  output logic [OUT_W-1:0]   cos_o
);

  logic [PHASE_W:0]   in_q;
  logic [PHASE_W-1:0] ph_i;
  logic               nd_i;
  logic signed [OUT_W-1:0] sin_c;
  logic signed [OUT_W-1:0] cos_c;
  logic [2*OUT_W:0]   out_q;

  sincos_pipe #(.W(PHASE_W + 1), .D(IN_D)) u_in (
    .clk (clk), .rst_n (rst_n), .aclr (aclr), .sclr (sclr), .ce (ce),
    .d   ({nd, phase}),
    .q   (in_q)
  );

  assign {nd_i, ph_i} = in_q;

  if (EN_SIN) begin : g_sin
    sincos_fold #(.PHASE_W(PHASE_W), .OUT_W(OUT_W), .SYM(SYMMETRIC), .COS(1'b0), .NEG(NEG_SIN)) u_fold (
      .phase (ph_i),
      .val   (sin_c)
    );
  end else begin : g_nosin
    assign sin_c = '0;
  end

  if (EN_COS) begin : g_cos
    sincos_fold #(.PHASE_W(PHASE_W), .OUT_W(OUT_W), .SYM(SYMMETRIC), .COS(1'b1), .NEG(NEG_COS)) u_fold (
      .phase (ph_i),
      .val   (cos_c)
    );
  end else begin : g_nocos
    assign cos_c = '0;
  end

  sincos_pipe #(.W(2 * OUT_W + 1), .D(OUT_D)) u_out (
    .clk (clk), .rst_n (rst_n), .aclr (aclr), .sclr (sclr), .ce (ce),
    .d   ({nd_i, sin_c, cos_c}),
    .q   (out_q)
  );

  assign {rdy, sin_o, cos_o} = out_q;
  assign rfd = 1'b1;

endmodule

// File: rtl/sincos_qlut_chk.sv
module sincos_qlut_chk #(
  parameter int OUT_W     = 12,
  parameter bit SYMMETRIC = 1'b0,
  parameter bit IN_REG    = 1'b1,
  parameter bit OUT_REG   = 1'b1,
  localparam int LIM      = SYMMETRIC ? (1 << (OUT_W - 2)) : ((1 << (OUT_W - 1)) - 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             aclr,
  input logic             sclr,
  input logic             ce,
  input logic             rdy,
  input logic [OUT_W-1:0] sin_o,
  input logic [OUT_W-1:0] cos_o
);

  // R3 R4
  sin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(sin_o) <= LIM) && ($signed(sin_o) >= -LIM));

  // R3 R4
  cos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(cos_o) <= LIM) && ($signed(cos_o) >= -LIM));

  if (IN_REG || OUT_REG) begin : g_seq
    // R7
    ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || aclr)
      (!ce && !sclr) |=> ($stable(sin_o) && $stable(cos_o) && $stable(rdy)));
  end

  if (OUT_REG) begin : g_clr
    // R8
    sclr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || aclr)
      sclr |=> (sin_o == '0 && cos_o == '0 && !rdy));

    // R9
    aclr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aclr |-> (sin_o == '0 && cos_o == '0 && !rdy));
  end

endmodule

bind sincos_qlut sincos_qlut_chk #(
  .OUT_W(OUT_W), .SYMMETRIC(SYMMETRIC), .IN_REG(IN_REG), .OUT_REG(OUT_REG)
) u_chk (.*);

// File: tb/sim_sincos_qlut.sv
module sim_sincos_qlut;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int OW = 12;
  localparam int N  = 1 << PW;
  localparam int L0 = 3;
  localparam int L1 = 1;

  logic clk = 1'b0;
  logic rst_n, aclr, sclr, ce, nd;
  logic [PW-1:0] phase;
  logic rfd0, rdy0, rfd1, rdy1, rfd2, rdy2;
  logic [OW-1:0] s0, c0, s1, c1, s2, c2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int ph_hist [N];
  bit nd_hist [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  // non-symmetric, registered in and out, one extra stage
  sincos_qlut #(.PHASE_W(PW), .OUT_W(OW), .SYMMETRIC(1'b0), .NEG_SIN(1'b0), .NEG_COS(1'b0),
                .IN_REG(1'b1), .OUT_REG(1'b1), .PIPE(1)) u0 (
    .clk(clk), .rst_n(rst_n), .aclr(aclr), .sclr(sclr), .ce(ce), .nd(nd), .phase(phase),
    .rfd(rfd0), .rdy(rdy0), .sin_o(s0), .cos_o(c0));

  // symmetric, cosine inverted, output register only
  sincos_qlut #(.PHASE_W(PW), .OUT_W(OW), .SYMMETRIC(1'b1), .NEG_SIN(1'b0), .NEG_COS(1'b1),
                .IN_REG(1'b0), .OUT_REG(1'b1), .PIPE(0)) u1 (
    .clk(clk), .rst_n(rst_n), .aclr(aclr), .sclr(sclr), .ce(ce), .nd(nd), .phase(phase),
    .rfd(rfd1), .rdy(rdy1), .sin_o(s1), .cos_o(c1));

  // combinational, sine only
  sincos_qlut #(.PHASE_W(PW), .OUT_W(OW), .EN_COS(1'b0),
                .IN_REG(1'b0), .OUT_REG(1'b0), .PIPE(0)) u2 (
    .clk(clk), .rst_n(rst_n), .aclr(aclr), .sclr(sclr), .ce(ce), .nd(nd), .phase(phase),
    .rfd(rfd2), .rdy(rdy2), .sin_o(s2), .cos_o(c2));

  function automatic int ref_val(int p, bit use_cos, bit sym, bit neg);
    real ang, v, r;
    int e, lim;
    ang = (real'(p) + 0.5) * 2.0 * 3.14159265358979323846 / real'(N);
    v   = use_cos ? $cos(ang) : $sin(ang);
    r   = v * (sym ? real'(1 << (OW - 2)) : real'(1 << (OW - 1)));
    e   = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    lim = sym ? (1 << (OW - 2)) : ((1 << (OW - 1)) - 1);
    if (e > lim) e = lim;
    if (e < -lim) e = -lim;
    return neg ? -e : e;
  endfunction

  task automatic chk(string req, int act, int exp, int tol);
    int diff;
    checks++;
    diff = act - exp;
    if (diff < 0) diff = -diff;
    if (diff > tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sv(logic [OW-1:0] x);
    return int'($signed(x));
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int hs, hc, hr;
    rst_n = 1'b1; aclr = 1'b0; sclr = 1'b0; ce = 1'b1; nd = 1'b0; phase = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 u0 sin", sv(s0), 0, 0);
    chk("R11 u0 cos", sv(c0), 0, 0);
    chk("R11 u0 rdy", int'(rdy0), 0, 0);
    chk("R11 u1 sin", sv(s1), 0, 0);
    chk("R11 u1 rdy", int'(rdy1), 0, 0);
    rst_n = 1'b1;

    // Full sweep of every phase, streaming one per cycle
    for (int j = 0; j < N + L0; j++) begin
      @(negedge clk);
      if (j >= L0) begin
        chk("R1 R3 u0 sin", sv(s0), ref_val(ph_hist[j-L0], 1'b0, 1'b0, 1'b0), 1);
        chk("R2 R3 u0 cos", sv(c0), ref_val(ph_hist[j-L0], 1'b1, 1'b0, 1'b0), 1);
        chk("R6 R10 u0 rdy", int'(rdy0), int'(nd_hist[j-L0]), 0);
      end
      if (j >= L1 && j - L1 < N) begin
        chk("R1 R4 u1 sin", sv(s1), ref_val(ph_hist[j-L1], 1'b0, 1'b1, 1'b0), 1);
        chk("R2 R4 R5 u1 cos", sv(c1), ref_val(ph_hist[j-L1], 1'b1, 1'b1, 1'b1), 1);
        chk("R6 R10 u1 rdy", int'(rdy1), int'(nd_hist[j-L1]), 0);
      end
      if (j < N) begin
        phase = PW'(j);
        nd    = (j % 3) != 0;
        ph_hist[j] = j;
        nd_hist[j] = nd;
        #1;
        chk("R1 R6 u2 sin", sv(s2), ref_val(j, 1'b0, 1'b0, 1'b0), 1);
        chk("R12 u2 cos", sv(c2), 0, 0);
        chk("R10 u2 rdy", int'(rdy2), int'(nd), 0);
      end else begin
        phase = '0;
        nd    = 1'b0;
      end
    end
    chk("R10 rfd", int'(rfd0 & rfd1 & rfd2), 1, 0);

    // R7: ce low freezes the pipeline
    phase = 8'd37; nd = 1'b1;
    repeat (4) @(negedge clk);
    hs = sv(s0); hc = sv(c0); hr = int'(rdy0);
    chk("R1 u0 sin settle", hs, ref_val(37, 1'b0, 1'b0, 1'b0), 1);
    ce = 1'b0; phase = 8'd200; nd = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 u0 sin hold", sv(s0), hs, 0);
    chk("R7 u0 cos hold", sv(c0), hc, 0);
    chk("R7 u0 rdy hold", int'(rdy0), hr, 0);
    ce = 1'b1;
    repeat (L0) @(negedge clk);
    chk("R6 u0 sin after ce", sv(s0), ref_val(200, 1'b0, 1'b0, 1'b0), 1);
    chk("R10 u0 rdy after ce", int'(rdy0), 0, 0);

    // R8: sclr clears even with ce low
    phase = 8'd90; nd = 1'b1;
    repeat (4) @(negedge clk);
    ce = 1'b0; sclr = 1'b1;
    @(negedge clk);
    chk("R8 u0 sin", sv(s0), 0, 0);
    chk("R8 u0 cos", sv(c0), 0, 0);
    chk("R8 u0 rdy", int'(rdy0), 0, 0);
    chk("R8 u1 cos", sv(c1), 0, 0);
    sclr = 1'b0; ce = 1'b1;

    // R9: aclr mid-cycle clears at once
    phase = 8'd100; nd = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 u0 cos before aclr", sv(c0), ref_val(100, 1'b1, 1'b0, 1'b0), 1);
    #2 aclr = 1'b1;
    #1;
    chk("R9 u0 sin", sv(s0), 0, 0);
    chk("R9 u0 cos", sv(c0), 0, 0);
    chk("R9 u0 rdy", int'(rdy0), 0, 0);
    chk("R9 u1 sin", sv(s1), 0, 0);
    @(negedge clk);
    aclr = 1'b0;
    repeat (L0 + 1) @(negedge clk);
    chk("R9 u0 recovers", sv(c0), ref_val(100, 1'b1, 1'b0, 1'b0), 1);

    finish_run();
  end

endmodule